// File: doc/BRIEF.md
# Command/Address Parity Guard

This block sits between the command/address pins of a DDR4-style memory device and its command decoder. Each cycle in which chip select is low, it folds the command pins, the bank-group and bank bits, the 18 address bits and the parity pin into one even-parity result. If the parity check is switched on and that result is odd, the command is dropped. The active-low alert output is then held low for a long recovery window, during which the input pins are neither forwarded nor checked. A command that passes appears on a registered command bus one cycle later.

The same alert pin also reports write-CRC errors. A one-cycle request on `crc_err_req` pulls the alert low for a short, fixed window. A parity error also sets a sticky flag, which stays set after the alert has gone high again and is cleared only by a pulse on `err_clear`.

The forwarded command stream carries a valid strobe and no ready. A memory device cannot stall its controller, so the consumer must accept `cmd_valid_out` in every cycle it is high. No back-pressure exists, and nothing is buffered.

Top module: `ca_parity_guard`

## Requirements
- R1: With `par_chk_en` high, a sampled command is in error when the XOR of `act_n`, `ras_n`, `cas_n`, `we_n`, `bg`, `ba`, `addr` and `par` is 1. A result of 0 is correct parity.
- R2: While `cs_n` is high, nothing is sampled. `cmd_valid_out` is low one cycle later, and no parity error is raised.
- R3: While `par_chk_en` is low, odd parity raises no alert and does not set the flag, and the command is forwarded.
- R4: A parity error sampled at clock edge t drives `alert_n` low from edge t to edge t+PAR_HOLD, which is PAR_HOLD cycles (default 64).
- R5: While the parity recovery window runs (edges t+1 to t+PAR_HOLD), incoming commands are not forwarded and are not checked, so bad parity there neither extends nor restarts the window.
- R6: A `crc_err_req` pulse at edge t drives `alert_n` low for CRC_PULSE cycles (default 8). A new request while that window runs restarts it at the full length.
- R7: When the parity and CRC windows overlap, `alert_n` is low whenever either one runs. A CRC request never shortens a parity window.
- R8: `par_err_flag` is set by a parity error and stays set until `err_clear` is high at a clock edge. If an error and a clear fall on the same edge, the flag ends up set.
- R9: A sampled command with no parity error is forwarded one cycle later, with `cmd_valid_out` high. `cmd_out` is {act_n, ras_n, cas_n, we_n, bg[1:0], ba[1:0], addr[17:0]}, MSB first. A command with a parity error is not forwarded.
- R10: While `rst_n` is low, and without waiting for a clock, `alert_n` is high, `cmd_valid_out` is low, `par_err_flag` is low, and both windows are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| act_n | input | 1 | Activate command pin |
| ras_n | input | 1 | Row strobe / address bit 16 |
| cas_n | input | 1 | Column strobe / address bit 15 |
| we_n | input | 1 | Write enable / address bit 14 |
| bg | input | 2 | Bank-group address |
| ba | input | 2 | Bank address |
| addr | input | 18 | Row/column address |
| par | input | 1 | Even-parity bit for the command and address pins |
| par_chk_en | input | 1 | Mode bit that enables the parity check |
| crc_err_req | input | 1 | One-cycle request for a short CRC alert |
| err_clear | input | 1 | Clears the sticky parity-error flag |
| cmd_valid_out | output | 1 | Forwarded command is valid this cycle |
| cmd_out | output | 26 | Forwarded command fields |
| alert_n | output | 1 | Alert, active low |
| par_err_flag | output | 1 | Sticky parity-error flag |

## Verification
Two events can land on the same edge. A parity error can arrive together with a CRC request, and a parity error can arrive together with a flag clear. The directed part of the bench forces both pairings. The random part keeps them happening by issuing CRC requests and clears at a low rate while commands with occasional bad parity keep starting recovery windows. The alert is judged every cycle against a model that holds the two windows apart and treats the alert as low while either runs. The flag is judged against the rule that a set and a clear on the same edge leave it set.

// File: rtl/ca_parity_pkg.sv
package ca_parity_pkg;
  localparam int ADDR_W = 18;
  localparam int BG_W   = 2;
  localparam int BA_W   = 2;
  // act_n, ras_n, cas_n, we_n + bank group + bank + address
  localparam int CMD_W  = 4 + BG_W + BA_W + ADDR_W;
endpackage

// File: rtl/ca_parity_calc.sv
module ca_parity_calc #(
  parameter int W = 8,
  parameter bit SPLIT = 1'b1
) (
  input  logic [W-1:0] bits,
  output logic         odd
);
  localparam int HALF = W / 2;

  generate
    if (SPLIT && W > 3) begin : g_split
      logic lo_odd, hi_odd;
      assign lo_odd = ^bits[HALF-1:0];
      assign hi_odd = ^bits[W-1:HALF];
      assign odd    = lo_odd ^ hi_odd;
    end else begin : g_flat
      assign odd = ^bits;
    end
  endgenerate
endmodule

// File: rtl/ca_hold_timer.sv
module ca_hold_timer #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_V = CW'(LEN);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           remain <= '0;
    else if (load)        remain <= LEN_V;
    else if (remain != 0) remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

  // R4 / R6: once loaded, the window runs down without stalling
  assert_window_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load) |=> (remain < $past(remain)));
  assert_window_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active);
endmodule

// File: rtl/ca_parity_guard.sv
module ca_parity_guard
  import ca_parity_pkg::*;
#(
  parameter int PAR_HOLD  = 64,
  parameter int CRC_PULSE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              act_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BG_W-1:0]   bg,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              par,
  input  logic              par_chk_en,
  input  logic              crc_err_req,
  input  logic              err_clear,
  output logic              cmd_valid_out,
  output logic [CMD_W-1:0]  cmd_out,
  output logic              alert_n,
  output logic              par_err_flag
);
  logic [CMD_W-1:0] cmd_bus;
  logic par_odd, rec_busy, crc_busy, sampled, par_err_evt;

  assign cmd_bus = {act_n, ras_n, cas_n, we_n, bg, ba, addr};

  ca_parity_calc #(.W(CMD_W + 1), .SPLIT(1'b1)) u_par (
    .bits ({cmd_bus, par}),
    .odd  (par_odd)
  );

  // Commands are looked at only outside a recovery window
  assign sampled     = !cs_n && !rec_busy;
  assign par_err_evt = sampled && par_chk_en && par_odd;

  ca_hold_timer #(.LEN(PAR_HOLD)) u_rec (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (par_err_evt),
    .active (rec_busy)
  );

  ca_hold_timer #(.LEN(CRC_PULSE)) u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (crc_err_req),
    .active (crc_busy)
  );

  assign alert_n = !(rec_busy || crc_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid_out <= 1'b0;
      cmd_out       <= '0;
    end else begin
      cmd_valid_out <= sampled && !par_err_evt;
      if (sampled && !par_err_evt) cmd_out <= cmd_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           par_err_flag <= 1'b0;
    else if (par_err_evt) par_err_flag <= 1'b1;
    else if (err_clear)   par_err_flag <= 1'b0;
  end

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !cmd_valid_out);
  assert_no_fwd_in_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_busy |=> !cmd_valid_out);
  assert_alert_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_evt |=> (!alert_n && !cmd_valid_out));
  assert_crc_alert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err_req |=> !alert_n);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err_flag && !err_clear) |=> par_err_flag);
  assert_flag_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    par_err_evt |=> par_err_flag);
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_chk_en && !cs_n && !rec_busy) |=> cmd_valid_out);
endmodule

// File: tb/sim_ca_parity_guard.sv
module sim_ca_parity_guard;
  import ca_parity_pkg::*;

  localparam int H = 64;
  localparam int C = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, act_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [BG_W-1:0] bg = '0;
  logic [BA_W-1:0] ba = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic par = 1'b0, par_chk_en = 1'b0, crc_err_req = 1'b0, err_clear = 1'b0;
  logic cmd_valid_out, alert_n, par_err_flag;
  logic [CMD_W-1:0] cmd_out;

  always #5 clk = ~clk;

  ca_parity_guard #(.PAR_HOLD(H), .CRC_PULSE(C)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .act_n(act_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .bg(bg), .ba(ba), .addr(addr), .par(par),
    .par_chk_en(par_chk_en), .crc_err_req(crc_err_req), .err_clear(err_clear),
    .cmd_valid_out(cmd_valid_out), .cmd_out(cmd_out), .alert_n(alert_n),
    .par_err_flag(par_err_flag)
  );

  int n_tot = 0, n_fail = 0;
  int m_rec = 0, m_crc = 0;
  logic m_valid = 1'b0, m_flag = 1'b0;
  logic [CMD_W-1:0] m_cmd = '0;
  string v_tag = "R9", f_tag = "R8";

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_alert_n(input int r, input int c);
    return (r == 0) && (c == 0);
  endfunction

  function automatic string alert_tag(input int r, input int c);
    if (r != 0 && c != 0) return "R7";
    if (c != 0) return "R6";
    return "R4";
  endfunction

  task automatic compare();
    chk(v_tag, 64'(cmd_valid_out), 64'(m_valid));
    if (m_valid) chk("R9", 64'(cmd_out), 64'(m_cmd));
    chk(alert_tag(m_rec, m_crc), 64'(alert_n), 64'(exp_alert_n(m_rec, m_crc)));
    chk(f_tag, 64'(par_err_flag), 64'(m_flag));
  endtask

  // Drive one cycle: inputs after a falling edge, model at the rising edge.
  task automatic step(input logic cs_i, input logic bad, input logic en_i,
                      input logic crc_i, input logic clr_i);
    logic [CMD_W-1:0] bus;
    logic busy, err;
    {act_n, ras_n, cas_n, we_n} = 4'($urandom);
    bg = BG_W'($urandom); ba = BA_W'($urandom); addr = ADDR_W'($urandom);
    bus = {act_n, ras_n, cas_n, we_n, bg, ba, addr};
    par = (^bus) ^ bad;
    cs_n = cs_i; par_chk_en = en_i; crc_err_req = crc_i; err_clear = clr_i;
    @(posedge clk);
    #1;
    busy = (m_rec != 0);
    err  = !cs_i && !busy && en_i && bad;
    v_tag = cs_i ? "R2" : busy ? "R5" : err ? "R1" : !en_i ? "R3" : "R9";
    f_tag = err ? "R1" : "R8";
    m_valid = !cs_i && !busy && !err;
    if (m_valid) m_cmd = bus;
    m_rec = err ? H : (m_rec != 0 ? m_rec - 1 : 0);
    m_crc = crc_i ? C : (m_crc != 0 ? m_crc - 1 : 0);
    if (err) m_flag = 1'b1;
    else if (clr_i) m_flag = 1'b0;
    @(negedge clk);
    compare();
  endtask

  task automatic check_reset();
    chk("R10", 64'(cmd_valid_out), 64'd0);
    chk("R10", 64'(alert_n), 64'd1);
    chk("R10", 64'(par_err_flag), 64'd0);
    m_rec = 0; m_crc = 0; m_valid = 1'b0; m_flag = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (2) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    // Good command forwarded (R9), bad parity with check off (R3)
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);   // R2: deselected
    // Parity error and CRC request on the same edge (R7), then bad commands in recovery (R5)
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < H + 4; i++) step(1'b0, (i % 3) == 0, 1'b1, 1'b0, 1'b0);
    // Error and clear on the same edge: set wins (R8), then clear alone
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < H + 2; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    // CRC retrigger inside its own window (R6), CRC inside parity window (R7)
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < C + 2; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < H - 3; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < C + 4; i++) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // Random phase
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 4, ($urandom % 100) < 4, (i / 500) % 4 != 3,
           ($urandom % 100) < 3, ($urandom % 100) < 3);
    // Asynchronous reset in mid-window (R10)
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    #2 rst_n = 1'b0;
    #1 check_reset();
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end
endmodule